// File: doc/BRIEF.md
# Multi-Channel Stream Link Hub

The hub sits between a small processor register bus and a set of streaming channels. It has up to eight outbound channels (processor to fabric) and up to eight inbound channels (fabric to processor). Every channel carries a 32-bit word and uses a valid/ready handshake: a word moves only on a rising clock edge where valid and ready are both high. Each channel has its own FIFO, so a slow consumer on one channel never stalls another.

Software pushes a word by writing the data register of an outbound channel. It pops a word by reading the data register of an inbound channel. A status register shows, for every channel, whether it can take another word or has one waiting. The number of outbound and inbound channels and their FIFO depths are parameters. The top-level ports always carry all eight channels in each direction, and channels beyond the configured counts are held inactive inside the block.

Bus map (word address `bus_addr[4:0]`): `0x00+n` is the outbound data register of channel n (write only). `0x08+n` is the inbound data register of channel n (read only). `0x10` is status, with bits [7:0] = outbound channel n not full and bits [15:8] = inbound channel n not empty. All other reads return 0. Reads are combinational in the cycle `bus_re` is high, and the pop takes effect at the following edge.

Top module: `stream_link_hub`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every `tx_valid` and `rx_ready` bit is 0. Reset empties every FIFO.
- R2: A write to address `0x00+n` for a configured outbound channel n appends `bus_wdata` to that channel's FIFO. `tx_valid[n]` is high whenever the FIFO holds a word, and `tx_data[32n+:32]` is the oldest word.
- R3: An outbound word leaves only on an edge where `tx_valid[n]` and `tx_ready[n]` are both high. While valid is high and ready is low, `tx_data` for that channel holds steady.
- R4: A write to a full outbound FIFO is dropped, and the FIFO's contents and order are unchanged.
- R5: `rx_ready[n]` of a configured inbound channel is high whenever its FIFO is not full. A word offered on an edge with valid and ready high is stored. A read of `0x08+n` returns the oldest stored word and removes it.
- R6: A read of an inbound channel whose FIFO is empty returns 0 and leaves the FIFO unchanged.
- R7: A read of `0x10` returns outbound not-full flags in bits [7:0] and inbound not-empty flags in bits [15:8]. Bits for unconfigured channels read 0, and bits [31:16] read 0.
- R8: Unconfigured channels keep `tx_valid` and `rx_ready` at 0. Writes and reads addressed to them have no effect and reads return 0.
- R9: Channels are independent. Traffic or bus accesses on one channel never change another channel's contents.
- R10: An outbound FIFO holds exactly `TX_DEPTH` words, and an inbound FIFO holds exactly `RX_DEPTH` words, before reporting full.
- R11: Writes to inbound or status addresses, and reads of outbound addresses or unmapped addresses, change nothing and read back 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_re` is high |
| tx_data | output | 256 | Outbound payloads, channel n in bits [32n+31:32n] |
| tx_valid | output | 8 | Outbound valid, one per channel |
| tx_ready | input | 8 | Outbound ready from sinks |
| rx_data | input | 256 | Inbound payloads, channel n in bits [32n+31:32n] |
| rx_valid | input | 8 | Inbound valid from sources |
| rx_ready | output | 8 | Inbound ready, one per channel |

## Verification
The bench fills an outbound FIFO to its depth and then writes once more. A hub that accepted the extra write would either overwrite the oldest word or send five words where four were expected. It holds ready low for several cycles to catch a head word that drifts while it waits. It reads an empty inbound channel, an unconfigured channel, an outbound address and an unmapped address. A design that popped anyway or leaked stale data would return a nonzero word, or would lose a later word. Asserting reset with words still buffered shows whether a hub keeps stale words or raises ready while in reset.

// File: rtl/slink_pkg.sv
package slink_pkg;
  localparam int MAX_LINKS = 8;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 5;
  localparam int SEL_W     = $clog2(MAX_LINKS);

  typedef logic [DATA_W-1:0] word_t;

  // Upper address bits pick the register group.
  typedef enum logic [1:0] {
    GRP_TX     = 2'b00,
    GRP_RX     = 2'b01,
    GRP_STATUS = 2'b10,
    GRP_NONE   = 2'b11
  } addr_grp_e;
endpackage

// File: rtl/slink_fifo.sv
module slink_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  function automatic logic [PW-1:0] advance(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head_data = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = advance(wr_q);
    if (pop_ok)  rd_d = advance(rd_q);
    unique case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage carries no reset; the write enable is the accepted push.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_data;
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(cnt_q)));

  assert_head_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop) |=> $stable(head_data));

  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);

  assert_depth_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/slink_bus_decode.sv
module slink_bus_decode
  import slink_pkg::*;
(
  input  logic                          bus_we,
  input  logic                          bus_re,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [MAX_LINKS-1:0][DATA_W-1:0] rx_head,
  input  logic [MAX_LINKS-1:0]          rx_nempty,
  input  logic [MAX_LINKS-1:0]          tx_nfull,
  output logic [MAX_LINKS-1:0]          tx_push,
  output logic [MAX_LINKS-1:0]          rx_pop,
  output logic [DATA_W-1:0]             bus_rdata
);
  logic [SEL_W-1:0] sel;
  addr_grp_e        grp;

  assign sel = bus_addr[SEL_W-1:0];
  assign grp = addr_grp_e'(bus_addr[ADDR_W-1:SEL_W]);

  always_comb begin
    tx_push   = '0;
    rx_pop    = '0;
    bus_rdata = '0;
    unique case (grp)
      GRP_TX: begin
        if (bus_we) tx_push[sel] = 1'b1;
      end
      GRP_RX: begin
        if (bus_re && rx_nempty[sel]) begin
          rx_pop[sel] = 1'b1;
          bus_rdata   = rx_head[sel];
        end
      end
      GRP_STATUS: begin
        if (bus_re && sel == '0)
          bus_rdata = {{(DATA_W - 2*MAX_LINKS){1'b0}}, rx_nempty, tx_nfull};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stream_link_hub.sv
module stream_link_hub
  import slink_pkg::*;
#(
  parameter int NUM_TX   = 8,
  parameter int NUM_RX   = 8,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic         bus_re,
  input  logic [4:0]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  output logic [255:0] tx_data,
  output logic [7:0]   tx_valid,
  input  logic [7:0]   tx_ready,
  input  logic [255:0] rx_data,
  input  logic [7:0]   rx_valid,
  output logic [7:0]   rx_ready
);
  logic [MAX_LINKS-1:0][DATA_W-1:0] rx_head;
  logic [MAX_LINKS-1:0]             rx_nempty, tx_nfull, tx_push, rx_pop;
  logic                             run_q, run_d;

  // Ready outputs stay low until the first edge after reset release.
  assign run_d = 1'b1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  slink_bus_decode u_dec (
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .rx_head   (rx_head),
    .rx_nempty (rx_nempty),
    .tx_nfull  (tx_nfull),
    .tx_push   (tx_push),
    .rx_pop    (rx_pop),
    .bus_rdata (bus_rdata)
  );

  for (genvar i = 0; i < MAX_LINKS; i++) begin : g_tx
    if (i < NUM_TX) begin : g_on
      logic tx_full, tx_empty;
      slink_fifo #(.DEPTH(TX_DEPTH), .WIDTH(DATA_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push[i]),
        .push_data (bus_wdata),
        .pop       (tx_ready[i]),
        .head_data (tx_data[i*DATA_W +: DATA_W]),
        .full      (tx_full),
        .empty     (tx_empty)
      );
      assign tx_valid[i] = ~tx_empty;
      assign tx_nfull[i] = ~tx_full;
    end else begin : g_off
      logic unused_tx;
      assign unused_tx = tx_ready[i] ^ tx_push[i];
      assign tx_data[i*DATA_W +: DATA_W] = '0;
      assign tx_valid[i] = 1'b0;
      assign tx_nfull[i] = 1'b0;
    end
  end

  for (genvar i = 0; i < MAX_LINKS; i++) begin : g_rx
    if (i < NUM_RX) begin : g_on
      logic rx_full, rx_empty;
      slink_fifo #(.DEPTH(RX_DEPTH), .WIDTH(DATA_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_valid[i] & rx_ready[i]),
        .push_data (rx_data[i*DATA_W +: DATA_W]),
        .pop       (rx_pop[i]),
        .head_data (rx_head[i]),
        .full      (rx_full),
        .empty     (rx_empty)
      );
      assign rx_ready[i]  = run_q & ~rx_full;
      assign rx_nempty[i] = ~rx_empty;
    end else begin : g_off
      logic unused_rx;
      assign unused_rx = ^{rx_data[i*DATA_W +: DATA_W], rx_valid[i], rx_pop[i]};
      assign rx_head[i]   = '0;
      assign rx_ready[i]  = 1'b0;
      assign rx_nempty[i] = 1'b0;
    end
  end

  assert_rx_empty_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr[4:3] == 2'b01 && !rx_nempty[bus_addr[2:0]]) |-> (bus_rdata == '0));

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (rx_ready == '0 && tx_valid == '0));
endmodule

// File: tb/sim_stream_link_hub.sv
`timescale 1ns/1ps
module sim_stream_link_hub;
  localparam int NTX = 3;
  localparam int NRX = 2;
  localparam int TXD = 4;
  localparam int RXD = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_we, bus_re;
  logic [4:0]   bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic [255:0] tx_data, rx_data;
  logic [7:0]   tx_valid, tx_ready, rx_valid, rx_ready;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  stream_link_hub #(.NUM_TX(NTX), .NUM_RX(NRX), .TX_DEPTH(TXD), .RX_DEPTH(RXD)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  // Vector: {op (1 write, 2 read), addr, wdata, expected read data}
  localparam int NV = 16;
  localparam logic [70:0] VEC [NV] = '{
    {2'd2, 5'h10, 32'h0,        32'h7},  // R7 status after reset
    {2'd1, 5'h00, 32'hA000_0001, 32'h0}, // R2
    {2'd1, 5'h00, 32'hA000_0002, 32'h0},
    {2'd1, 5'h01, 32'hB000_0001, 32'h0}, // R9 other channel
    {2'd2, 5'h10, 32'h0,        32'h7},
    {2'd1, 5'h00, 32'hA000_0003, 32'h0},
    {2'd1, 5'h00, 32'hA000_0004, 32'h0},
    {2'd2, 5'h10, 32'h0,        32'h6},  // R10 full at depth
    {2'd1, 5'h00, 32'hA000_0005, 32'h0}, // R4 dropped
    {2'd2, 5'h08, 32'h0,        32'h0},  // R6 empty read
    {2'd2, 5'h0F, 32'h0,        32'h0},  // R8 unconfigured read
    {2'd1, 5'h05, 32'hC000_0001, 32'h0}, // R8 unconfigured write
    {2'd1, 5'h09, 32'hD000_0009, 32'h0}, // R11 write to inbound
    {2'd2, 5'h10, 32'h0,        32'h6},
    {2'd2, 5'h02, 32'h0,        32'h0},  // R11 outbound not readable
    {2'd2, 5'h11, 32'h0,        32'h0}   // R11 unmapped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [4:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
    @(posedge clk);
    #1 bus_re = 1'b0;
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
    tx_ready = '0; rx_valid = '0; rx_data = '0;
    #1 chk("R1 tx_valid in reset", {24'h0, tx_valid}, 32'h0);
    chk("R1 rx_ready in reset", {24'h0, rx_ready}, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 chk("R1 rx_ready first cycle", {24'h0, rx_ready}, 32'h0);
    @(posedge clk);
    #1 chk("R5 rx_ready after reset", {24'h0, rx_ready}, 32'h3);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][70:69] == 2'd1) bus_write(VEC[v][68:64], VEC[v][63:32]);
      else bus_read(VEC[v][68:64], VEC[v][31:0], $sformatf("vector %0d", v));
    end

    // R2 R8: valid only on loaded configured channels
    @(negedge clk);
    #1 chk("R2 R8 tx_valid", {24'h0, tx_valid}, 32'h3);
    chk("R2 head ch0", tx_data[31:0], 32'hA000_0001);
    tx_ready[5] = 1'b1;
    // R3: head holds while ready is low
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1 chk("R3 head stable", tx_data[31:0], 32'hA000_0001);
    end
    // Drain channel 0 in order, R4: fifth word absent
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      tx_ready[0] = 1'b1;
      #1 chk("R2 drain valid", {31'h0, tx_valid[0]}, 32'h1);
      chk("R2 R4 drain order", tx_data[31:0], 32'hA000_0001 + k);
    end
    @(negedge clk);
    tx_ready[0] = 1'b0;
    #1 chk("R4 no extra word", {31'h0, tx_valid[0]}, 32'h0);
    chk("R9 ch1 untouched", tx_data[63:32], 32'hB000_0001);
    chk("R8 ch5 valid low", {31'h0, tx_valid[5]}, 32'h0);

    // Inbound channel 0
    @(negedge clk);
    rx_valid[0] = 1'b1; rx_data[31:0] = 32'hD000_0001;
    rx_valid[4] = 1'b1; rx_data[159:128] = 32'hEEEE_0004;
    #1 chk("R5 R8 rx_ready", {24'h0, rx_ready}, 32'h3);
    @(negedge clk);
    rx_data[31:0] = 32'hD000_0002;
    #1 chk("R5 ready second", {31'h0, rx_ready[0]}, 32'h1);
    @(negedge clk);
    rx_data[31:0] = 32'hD000_0003;
    #1 chk("R5 R10 full ready low", {31'h0, rx_ready[0]}, 32'h0);
    @(negedge clk);
    rx_valid = '0;
    bus_read(5'h10, 32'h0000_0107, "R7 status rx flag");
    bus_read(5'h08, 32'hD000_0001, "R5 pop first");
    bus_read(5'h08, 32'hD000_0002, "R5 pop second");
    bus_read(5'h08, 32'h0, "R6 empty after drain");
    bus_read(5'h09, 32'h0, "R9 R11 ch1 empty");
    bus_read(5'h0C, 32'h0, "R8 ch4 read");

    // R1: reset with a buffered word
    bus_write(5'h02, 32'h1234_5678);
    @(negedge clk);
    #1 chk("R2 ch2 valid", {31'h0, tx_valid[2]}, 32'h1);
    rst_n = 1'b0;
    #1 chk("R1 tx_valid async", {24'h0, tx_valid}, 32'h0);
    chk("R1 rx_ready async", {24'h0, rx_ready}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 chk("R1 emptied", {24'h0, tx_valid}, 32'h0);
    bus_read(5'h10, 32'h7, "R1 R7 status after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule